// File: doc/BRIEF.md
# Microprogrammed control sequencer

This block steps through a small microprogram of 16-bit words held in a parameter-defined program store. A program counter addresses the store. Each word is one of two kinds. An assert word drives a set of control outputs. A conditional branch word names one of eight condition lines and carries a target address. On every clock edge the counter either loads that target or moves on to the next address. The only way to branch is to load the counter conditionally. One condition line is tied permanently true, and selecting it gives an unconditional jump.

Status inputs arrive asynchronously. A chain of flip-flops brings them into the clock domain before they reach the condition multiplexer. Every control output comes straight from a flip-flop, so no output glitches while the program store settles. Each output has its own active level, set by a polarity parameter. A program bit of 1 means "assert", and the decoder turns that into a high or low pin level as the polarity requires. While a branch word executes, every output returns to its inactive level, because in a branch word the low bits hold an address and not control flags.

The block has no streaming data path. All of its pins are plain control and status signals, with no valid/ready handshake.

Top module: `useq_top`

## Requirements
- R1: Bit 15 of a word gives its kind: 1 marks an assert word and 0 marks a branch word. In a branch word, bits 14:12 select the condition and the low ADDR_W bits of field 11:0 give the target. In an assert word, bit i (for i from 0 to 14) controls ctrl_o[i].
- R2: While rst_n is low, upc_o is 0 and every ctrl_o bit sits at its inactive level, which is the inverse of ACTIVE_POL. The synchronizer stages are also cleared.
- R3: When a branch word with select k (1 to 7) executes and synchronized status bit k-1 is 1, upc_o equals the target after the edge.
- R4: Condition select 0 is always true, so a branch word with select 0 always loads its target.
- R5: After an assert word, or after a branch word whose condition is false, upc_o advances by one.
- R6: Advancing from address 2**ADDR_W-1 wraps upc_o to 0.
- R7: After the edge that ends an assert word, ctrl_o[i] equals ACTIVE_POL[i] if word bit i is 1, and equals the inverse of ACTIVE_POL[i] otherwise.
- R8: After the edge that ends a branch word, every ctrl_o bit is at its inactive level.
- R9: status_i passes through SYNC_STAGES flip-flops. A branch decision uses status values that were sampled SYNC_STAGES edges before the deciding edge.
- R10: An address at or above ROM_DEPTH reads as FILL_WORD. The default FILL_WORD, 16'h8000, is an assert word with no bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | 7 | Asynchronous status lines, read by condition selects 1 to 7 |
| upc_o | output | ADDR_W | Current program counter |
| ctrl_o | output | 15 | Registered control outputs, each with its own polarity |

## Verification
The first directed run holds every status line low. This drives the program through untaken branches, an unconditional jump into the unfilled region, the fill words and the wrap back to address 0. That separates select 0 from a real status line and confirms that the counter width and the fill rule are correct. A second run holds every status line high, so each conditional branch is taken. Comparing the two runs shows that the multiplexer follows the select field and loads the target rather than incrementing. Random status patterns, with resets at intervals, come next. Whenever a live status bit differs from its synchronized copy at a branch, the result shows whether the decision used the delayed value. In every run, an asymmetric polarity mask shows that the assert decoder maps "asserted" onto each pin's own level and releases every output during branch words.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UW      = 16;
  localparam int SEL_W   = 3;
  localparam int FIELD_W = 12;
  localparam int N_CTRL  = UW - 1;
  localparam int N_COND  = 1 << SEL_W;

  typedef logic [UW-1:0] uword_t;
  typedef enum logic {OP_BRANCH = 1'b0, OP_ASSERT = 1'b1} uop_e;

  function automatic uop_e op_of(uword_t w);
    return uop_e'(w[UW-1]);
  endfunction

  function automatic logic [SEL_W-1:0] sel_of(uword_t w);
    return w[UW-2 -: SEL_W];
  endfunction

  function automatic logic [FIELD_W-1:0] tgt_of(uword_t w);
    return w[FIELD_W-1:0];
  endfunction

  function automatic logic [N_CTRL-1:0] bits_of(uword_t w);
    return w[N_CTRL-1:0];
  endfunction
endpackage

// File: rtl/useq_sync.sv
module useq_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int NS = (STAGES < 1) ? 1 : STAGES;

  logic [NS-1:0][W-1:0] chain;

  // R9: plain shift chain; stage 0 captures the raw lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d_i;
      for (int s = 1; s < NS; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[NS-1];
endmodule

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int                    ADDR_W    = 12,
  parameter int                    ROM_DEPTH = 64,
  parameter logic [ROM_DEPTH*UW-1:0] PROGRAM = '0,
  parameter logic [UW-1:0]         FILL_WORD = 16'h8000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output uword_t            word_o
);
  localparam int SPAN = 1 << ADDR_W;

  generate
    if (ROM_DEPTH >= SPAN) begin : g_full
      always_comb word_o = PROGRAM[int'(addr_i)*UW +: UW];
    end else begin : g_part
      // R10: unpopulated addresses return the fill word
      always_comb begin
        if (int'(addr_i) < ROM_DEPTH) word_o = PROGRAM[int'(addr_i)*UW +: UW];
        else                           word_o = FILL_WORD;
      end
    end
  endgenerate
endmodule

// File: rtl/useq_cond_mux.sv
module useq_cond_mux #(
  parameter int SEL_W = 3
) (
  input  logic [(1<<SEL_W)-2:0] status_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic                  branch_i,
  output logic                  hit_o
);
  localparam int N = 1 << SEL_W;

  logic [N-1:0] lines;

  // R4: line 0 is tied true
  assign lines = {status_i, 1'b1};
  assign hit_o = branch_i & lines[sel_i];
endmodule

// File: rtl/useq_pc.sv
module useq_pc #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] tgt_i,
  output logic [ADDR_W-1:0] pc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_o <= '0;
    else if (load_i) pc_o <= tgt_i;
    else             pc_o <= pc_o + 1'b1;
  end
endmodule

// File: rtl/useq_assert_dec.sv
module useq_assert_dec #(
  parameter int         N   = 15,
  parameter logic [N-1:0] POL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         is_assert_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] ctrl_o
);
  logic [N-1:0] nxt;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (POL[i]) begin : g_hi
        assign nxt[i] = is_assert_i & bits_i[i];
      end else begin : g_lo
        assign nxt[i] = ~(is_assert_i & bits_i[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_o <= ~POL;
    else        ctrl_o <= nxt;
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int                      ADDR_W      = 12,
  parameter int                      ROM_DEPTH   = 64,
  parameter logic [ROM_DEPTH*UW-1:0] PROGRAM     = '0,
  parameter logic [UW-1:0]           FILL_WORD   = 16'h8000,
  parameter logic [N_CTRL-1:0]       ACTIVE_POL  = '1,
  parameter int                      SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_COND-2:0] status_i,
  output logic [ADDR_W-1:0] upc_o,
  output logic [N_CTRL-1:0] ctrl_o
);
  localparam int NSTAT = N_COND - 1;

  uword_t            uword;
  logic [NSTAT-1:0]  status_sync;
  logic              is_branch;
  logic              cond_hit;
  logic [ADDR_W-1:0] target;

  useq_sync #(.W(NSTAT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(status_i), .q_o(status_sync)
  );

  useq_rom #(.ADDR_W(ADDR_W), .ROM_DEPTH(ROM_DEPTH), .PROGRAM(PROGRAM),
             .FILL_WORD(FILL_WORD)) u_rom (
    .addr_i(upc_o), .word_o(uword)
  );

  assign is_branch = (op_of(uword) == OP_BRANCH);
  assign target    = ADDR_W'(tgt_of(uword));

  useq_cond_mux #(.SEL_W(SEL_W)) u_cmux (
    .status_i(status_sync), .sel_i(sel_of(uword)),
    .branch_i(is_branch), .hit_o(cond_hit)
  );

  useq_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .load_i(cond_hit), .tgt_i(target), .pc_o(upc_o)
  );

  useq_assert_dec #(.N(N_CTRL), .POL(ACTIVE_POL)) u_dec (
    .clk(clk), .rst_n(rst_n), .is_assert_i(!is_branch),
    .bits_i(bits_of(uword)), .ctrl_o(ctrl_o)
  );
endmodule

// File: rtl/useq_chk.sv
module useq_chk
  import useq_pkg::*;
#(
  parameter int                ADDR_W = 12,
  parameter logic [N_CTRL-1:0] POL    = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] upc,
  input logic [N_CTRL-1:0] ctrl,
  input uword_t            uword,
  input logic              cond_hit
);
  p_branch_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!uword[UW-1] && cond_hit) |=> (upc == $past(uword[ADDR_W-1:0])));

  p_select0_true_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!uword[UW-1] && uword[UW-2 -: SEL_W] == '0) |-> cond_hit);

  // also covers R6: the sum wraps at the counter width
  p_increment_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uword[UW-1] || !cond_hit) |=> (upc == ADDR_W'($past(upc) + 1'b1)));

  p_assert_levels_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uword[UW-1] |=> ((ctrl ~^ POL) == $past(uword[N_CTRL-1:0])));

  p_branch_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !uword[UW-1] |=> (ctrl == ~POL));
endmodule

bind useq_top useq_chk #(.ADDR_W(ADDR_W), .POL(ACTIVE_POL)) u_chk (
  .clk(clk), .rst_n(rst_n), .upc(upc_o), .ctrl(ctrl_o),
  .uword(uword), .cond_hit(cond_hit)
);

// File: tb/sim_useq_top.sv
module sim_useq_top;
  localparam int            AW    = 5;
  localparam int            DEPTH = 24;
  localparam logic [14:0]   POL   = 15'h5A3C;

  // R1 encodings used by the bench program
  function automatic logic [15:0] wa(logic [14:0] b);
    return {1'b1, b};
  endfunction
  function automatic logic [15:0] wb(logic [2:0] s, logic [11:0] t);
    return {1'b0, s, t};
  endfunction

  function automatic logic [15:0] bw(int i);
    case (i)
      0:  return wa(15'h0001);  1:  return wa(15'h4000);
      2:  return wa(15'h7FFF);  3:  return wa(15'h0000);
      4:  return wb(3'd1, 12'd12); 5: return wb(3'd2, 12'd16);
      6:  return wa(15'h2AAA);  7:  return wb(3'd3, 12'd20);
      8:  return wa(15'h5555);  9:  return wb(3'd4, 12'd3);
      10: return wb(3'd0, 12'd28); 11: return wa(15'h1111);
      12: return wa(15'h0F0F);  13: return wb(3'd5, 12'd4);
      14: return wa(15'h3C3C);  15: return wb(3'd0, 12'd22);
      16: return wa(15'h7001);  17: return wb(3'd6, 12'd0);
      18: return wa(15'h00FF);  19: return wb(3'd7, 12'd9);
      20: return wa(15'h6006);  21: return wb(3'd0, 12'h7F7);
      22: return wa(15'h0102);  23: return wa(15'h7FFE);
      default: return 16'h8000;
    endcase
  endfunction

  function automatic logic [DEPTH*16-1:0] mkprog();
    logic [DEPTH*16-1:0] r;
    r = '0;
    for (int i = 0; i < DEPTH; i++) r[i*16 +: 16] = bw(i);
    return r;
  endfunction

  localparam logic [DEPTH*16-1:0] PROG = mkprog();

  logic          clk = 1'b0;
  logic          rst_n;
  logic [6:0]    status;
  logic [AW-1:0] upc;
  logic [14:0]   ctrl;

  int checks = 0;
  int errors = 0;
  int mpc;
  logic [14:0] mctrl;
  logic [6:0]  ms1, ms2;

  always #4 clk = ~clk;

  useq_top #(.ADDR_W(AW), .ROM_DEPTH(DEPTH), .PROGRAM(PROG),
             .FILL_WORD(16'h8000), .ACTIVE_POL(POL), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .status_i(status), .upc_o(upc), .ctrl_o(ctrl)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 reset counter", {11'b0, upc}, 16'h0000);
    check("R2 reset outputs inactive", {1'b0, ctrl}, {1'b0, ~POL});
    mpc = 0; mctrl = ~POL; ms1 = '0; ms2 = '0;
    rst_n = 1'b1;
  endtask

  task automatic step(input logic [6:0] st);
    logic [15:0] w;
    logic        hit;
    int          k, old;
    string       tpc, tct;
    status = st;
    @(posedge clk);
    old = mpc;
    w   = bw(mpc);
    k   = int'(w[14:12]);
    hit = !w[15] && ((k == 0) ? 1'b1 : ms2[k-1]);
    if (!w[15] && k == 0)                    tpc = "R4 unconditional jump";
    else if (!w[15] && ms2[k-1] != st[k-1])  tpc = "R9 synchronized status";
    else if (hit)                            tpc = "R3 branch taken";
    else if (old == 31)                      tpc = "R6 wrap";
    else                                     tpc = "R5 increment";
    mpc = hit ? int'(w[AW-1:0]) : (old + 1) % 32;
    for (int i = 0; i < 15; i++) mctrl[i] = (w[15] && w[i]) ? POL[i] : !POL[i];
    if (!w[15])          tct = "R1/R8 branch outputs quiet";
    else if (old >= 24)  tct = "R10 fill word";
    else                 tct = "R1/R7 assert decode";
    ms2 = ms1; ms1 = st;
    #2;
    check(tpc, {11'b0, upc}, mpc[15:0]);
    check(tct, {1'b0, ctrl}, {1'b0, mctrl});
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n  = 1'b0;
    status = '0;
    @(negedge clk);
    do_reset();
    // quiet status: untaken branches, jump into fill region, wrap (R6, R10)
    repeat (24) step(7'h00);
    // all status high: conditional branches taken
    repeat (30) step(7'h7F);
    for (int n = 0; n < 3000; n++) begin
      if (n % 1000 == 999) do_reset();
      step(7'($urandom));
    end
    do_reset();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule